// File: doc/BRIEF.md
# Result Threshold Compare Monitor

This block sits beside a converter's result storage and watches every result written into one chosen sample slot. Each new result for that slot is checked against a 12-bit threshold. The block keeps a count of results that satisfy a programmable condition. The condition is either "below the threshold" or "at or above the threshold". When the count reaches a programmed number, the block sets a sticky flag. An interrupt follows the flag when interrupt enable is set. A live status bit always shows whether the most recently compared result was at or above the threshold.

Configuration arrives as one 32-bit word. Software clears the flag by pulsing a write-one-to-clear strobe. Each instance is one independent comparator, so two instances give two comparators that can watch different slots with different thresholds.

Top module: `thresh_cmp_monitor`

## Requirements
- R1: After reset, `cmp_flag`, `cmp_irq` and `cmp_out` are all 0.
- R2: A result is compared when it is a hit: a write to the selected slot while compare is enabled. On the clock edge that captures a hit, `cmp_out` becomes 1 if the result is greater than or equal to the threshold `cfg_word[27:16]`, and 0 otherwise. `cmp_out` is visible the cycle after the strobe.
- R3: `cfg_word[2]` chooses the condition. A value of 0 qualifies results strictly less than the threshold. A value of 1 qualifies results greater than or equal to it.
- R4: `cfg_word[11:8]` holds a match number M. An internal counter rises by one on every qualifying hit. On the edge of the hit that brings it to M+1, `cmp_flag` becomes 1 (with M = 0, the first qualifying hit sets it).
- R5: A hit that does not qualify returns the counter to zero, so the flag needs M+1 consecutive qualifying hits.
- R6: The slot select is `cfg_word[5:3]`. Codes 0 to 3 select group A (`wr_group` = 0) with index 0 to 3. Codes 4 to 7 select group B (`wr_group` = 1) with index 0 to 3. Writes to any other group or index change neither the counter nor `cmp_out`.
- R7: `cfg_word[0]` is the compare enable. While it is 0, no write is compared, `cmp_out` holds its value, the flag cannot set, and the counter returns to zero.
- R8: `cmp_flag` stays 1 until `clr_flag` is pulsed. If a set and a clear happen on the same edge, the set wins.
- R9: `cmp_irq` is 1 exactly when `cmp_flag` is 1 and `cfg_word[1]` is 1.
- R10: The counter returns to zero when the flag sets. After a clear, a fresh run of M+1 qualifying hits is needed to set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A result is being written this cycle |
| wr_group | input | 1 | Group of the written slot (0 = A, 1 = B) |
| wr_index | input | 3 | Slot index within the group |
| wr_data | input | 12 | Result value being written |
| cfg_word | input | 32 | Compare configuration word |
| clr_flag | input | 1 | Write-one-to-clear pulse for the flag |
| cmp_flag | output | 1 | Sticky compare flag |
| cmp_irq | output | 1 | Compare interrupt request |
| cmp_out | output | 1 | Latest compared result was at or above the threshold |

## Verification
The assertions check several relations on every cycle:
- the interrupt never rises without the flag, and stays low while masked;
- the flag stays set until a clear arrives;
- a clear with no competing write drops the flag;
- the flag can only rise after an enabled write;
- the status bit holds whenever no enabled write arrives.

Counting behaviour can only be shown by the bench's scenarios, which compare against an arithmetic model. This covers the exact hit on which the flag sets, counter resets on a miss or after a set, and threshold boundaries for both conditions. The scenarios also show the slot decode across every select code, group and index, and a set colliding with a clear.

// File: rtl/cmpmon_pkg.sv
package cmpmon_pkg;
    // Field placement inside the configuration word
    localparam int CFG_W        = 32;
    localparam int EN_BIT       = 0;
    localparam int IE_BIT       = 1;
    localparam int COND_BIT     = 2;
    localparam int SEL_LSB      = 3;
    localparam int MATCH_LSB    = 8;
    localparam int THR_LSB      = 16;

    // Default sizes
    localparam int DEF_DATA_W   = 12;
    localparam int DEF_CNT_W    = 4;
    localparam int DEF_SEL_W    = 3;
    localparam int DEF_IDX_W    = 3;

    typedef enum logic {
        COND_BELOW = 1'b0,
        COND_AT_OR_ABOVE = 1'b1
    } cmp_cond_e;
endpackage

// File: rtl/cmpmon_cfg_decode.sv
module cmpmon_cfg_decode
    import cmpmon_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int SEL_W  = DEF_SEL_W
) (
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              en,
    output logic              ie,
    output cmp_cond_e         cond,
    output logic [SEL_W-1:0]  sel,
    output logic [CNT_W-1:0]  match_num,
    output logic [DATA_W-1:0] thr
);
    localparam logic [CFG_W-1:0] SEL_MASK   = {{(CFG_W-SEL_W){1'b0}}, {SEL_W{1'b1}}} << SEL_LSB;
    localparam logic [CFG_W-1:0] MATCH_MASK = {{(CFG_W-CNT_W){1'b0}}, {CNT_W{1'b1}}} << MATCH_LSB;
    localparam logic [CFG_W-1:0] THR_MASK   = {{(CFG_W-DATA_W){1'b0}}, {DATA_W{1'b1}}} << THR_LSB;
    localparam logic [CFG_W-1:0] FLAG_MASK  = (CFG_W'(1) << EN_BIT) | (CFG_W'(1) << IE_BIT)
                                            | (CFG_W'(1) << COND_BIT);
    localparam logic [CFG_W-1:0] USED_MASK  = SEL_MASK | MATCH_MASK | THR_MASK | FLAG_MASK;

    logic unused_cfg_bits;

    always_comb begin
        en        = cfg_word[EN_BIT];
        ie        = cfg_word[IE_BIT];
        cond      = cmp_cond_e'(cfg_word[COND_BIT]);
        sel       = cfg_word[SEL_LSB +: SEL_W];
        match_num = cfg_word[MATCH_LSB +: CNT_W];
        thr       = cfg_word[THR_LSB +: DATA_W];
    end

    assign unused_cfg_bits = ^(cfg_word & ~USED_MASK);
endmodule

// File: rtl/cmpmon_slot_match.sv
module cmpmon_slot_match #(
    parameter int SEL_W = 3,
    parameter int IDX_W = 3
) (
    input  logic             wr_valid,
    input  logic             wr_group,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic             hit
);
    // The top select bit picks the group; the remaining bits pick an index.
    localparam int LOW_W = SEL_W - 1;

    logic [IDX_W-1:0] want_index;
    logic             want_group;

    generate
        if (IDX_W > LOW_W) begin : g_wide_index
            assign want_index = {{(IDX_W-LOW_W){1'b0}}, sel[LOW_W-1:0]};
        end else begin : g_same_index
            assign want_index = sel[IDX_W-1:0];
        end
    endgenerate

    assign want_group = sel[SEL_W-1];

    always_comb begin
        hit = wr_valid && en && (wr_group == want_group) && (wr_index == want_index);
    end
endmodule

// File: rtl/cmpmon_judge.sv
module cmpmon_judge
    import cmpmon_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] thr,
    input  cmp_cond_e         cond,
    output logic              at_or_above,
    output logic              qualifies
);
    always_comb begin
        at_or_above = (data >= thr);
        unique case (cond)
            COND_BELOW:       qualifies = !at_or_above;
            COND_AT_OR_ABOVE: qualifies = at_or_above;
            default:          qualifies = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmpmon_core.sv
module cmpmon_core #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ie,
    input  logic             hit,
    input  logic             at_or_above,
    input  logic             qualifies,
    input  logic [CNT_W-1:0] match_num,
    input  logic             clr_flag,
    output logic             flag,
    output logic             irq,
    output logic             live_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             live;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        set_now;

    always_comb begin
        st_d    = st_q;
        set_now = 1'b0;

        if (!en) begin
            st_d.cnt = '0;
        end else if (hit) begin
            st_d.live = at_or_above;
            if (qualifies) begin
                if (st_q.cnt == match_num) begin
                    set_now  = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end

        // A hardware set takes priority over a software clear on the same edge
        if (set_now) begin
            st_d.flag = 1'b1;
        end else if (clr_flag) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag     = st_q.flag;
    assign live_out = st_q.live;
    assign irq      = st_q.flag & ie;
endmodule

// File: rtl/thresh_cmp_monitor.sv
module thresh_cmp_monitor
    import cmpmon_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int SEL_W  = DEF_SEL_W,
    parameter int IDX_W  = DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_group,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              clr_flag,
    output logic              cmp_flag,
    output logic              cmp_irq,
    output logic              cmp_out
);
    logic              en;
    logic              ie;
    cmp_cond_e         cond;
    logic [SEL_W-1:0]  sel;
    logic [CNT_W-1:0]  match_num;
    logic [DATA_W-1:0] thr;
    logic              hit;
    logic              at_or_above;
    logic              qualifies;

    cmpmon_cfg_decode #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W)
    ) u_decode (
        .cfg_word  (cfg_word),
        .en        (en),
        .ie        (ie),
        .cond      (cond),
        .sel       (sel),
        .match_num (match_num),
        .thr       (thr)
    );

    cmpmon_slot_match #(
        .SEL_W (SEL_W),
        .IDX_W (IDX_W)
    ) u_slot (
        .wr_valid (wr_valid),
        .wr_group (wr_group),
        .wr_index (wr_index),
        .sel      (sel),
        .en       (en),
        .hit      (hit)
    );

    cmpmon_judge #(
        .DATA_W (DATA_W)
    ) u_judge (
        .data        (wr_data),
        .thr         (thr),
        .cond        (cond),
        .at_or_above (at_or_above),
        .qualifies   (qualifies)
    );

    cmpmon_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .ie          (ie),
        .hit         (hit),
        .at_or_above (at_or_above),
        .qualifies   (qualifies),
        .match_num   (match_num),
        .clr_flag    (clr_flag),
        .flag        (cmp_flag),
        .irq         (cmp_irq),
        .live_out    (cmp_out)
    );
endmodule

// File: rtl/cmpmon_checker.sv
module cmpmon_checker
    import cmpmon_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [CFG_W-1:0] cfg_word,
    input logic             clr_flag,
    input logic             cmp_flag,
    input logic             cmp_irq,
    input logic             cmp_out
);
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> cmp_flag); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_word[IE_BIT] |-> !cmp_irq); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !clr_flag) |=> cmp_flag); // R8

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && clr_flag && !wr_valid) |=> !cmp_flag); // R8

    AST_SET_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> $past(wr_valid && cfg_word[EN_BIT])); // R4

    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_word[EN_BIT] |=> !$rose(cmp_flag)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && cfg_word[EN_BIT]) |=> $stable(cmp_out)); // R2
endmodule

bind thresh_cmp_monitor cmpmon_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .cfg_word (cfg_word),
    .clr_flag (clr_flag),
    .cmp_flag (cmp_flag),
    .cmp_irq  (cmp_irq),
    .cmp_out  (cmp_out)
);

// File: tb/thresh_cmp_monitor_tb.sv
module thresh_cmp_monitor_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_group = 1'b0;
    logic [2:0]  wr_index = '0;
    logic [11:0] wr_data = '0;
    logic [31:0] cfg_word = '0;
    logic        clr_flag = 1'b0;
    logic        cmp_flag, cmp_irq, cmp_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state computed from the requirements
    int m_cnt  = 0;
    bit m_flag = 0;
    bit m_out  = 0;

    always #2 clk = ~clk;

    thresh_cmp_monitor u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_group (wr_group),
        .wr_index (wr_index),
        .wr_data  (wr_data),
        .cfg_word (cfg_word),
        .clr_flag (clr_flag),
        .cmp_flag (cmp_flag),
        .cmp_irq  (cmp_irq),
        .cmp_out  (cmp_out)
    );

    function automatic logic [31:0] mk_cfg(bit en, bit ie, bit cond, int sel, int match, int thr);
        logic [31:0] w = '0;
        w[0]     = en;
        w[1]     = ie;
        w[2]     = cond;
        w[5:3]   = sel[2:0];
        w[11:8]  = match[3:0];
        w[27:16] = thr[11:0];
        return w;
    endfunction

    task automatic check_bit(input string tag, input string what, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        check_bit(tag, "cmp_flag", cmp_flag, m_flag);
        check_bit(tag, "cmp_out", cmp_out, m_out);
        check_bit(tag, "cmp_irq", cmp_irq, m_flag & cfg_word[1]);
    endtask

    // Drive one cycle, advance the model, sample at the next falling edge
    task automatic step(input bit v, input bit g, input int ix, input int d, input bit c, input string tag);
        bit en, cond, hit, ge, qual, set;
        int sel, match, thr;
        wr_valid = v; wr_group = g; wr_index = ix[2:0]; wr_data = d[11:0]; clr_flag = c;
        en    = cfg_word[0];
        cond  = cfg_word[2];
        sel   = int'(cfg_word[5:3]);
        match = int'(cfg_word[11:8]);
        thr   = int'(cfg_word[27:16]);
        hit   = v && en && (g == (sel >= 4)) && (ix == (sel % 4));
        ge    = (d >= thr);
        qual  = cond ? ge : !ge;
        set   = hit && qual && (m_cnt == match);
        if (!en) m_cnt = 0;
        else if (hit) begin
            m_out = ge;
            if (!qual) m_cnt = 0;
            else if (set) m_cnt = 0;
            else m_cnt = m_cnt + 1;
        end
        if (set) m_flag = 1;
        else if (c) m_flag = 0;
        @(negedge clk);
        wr_valid = 1'b0; clr_flag = 1'b0;
        check_all(tag);
    endtask

    task automatic set_cfg(input logic [31:0] w);
        cfg_word = w;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all("R1");

        // R4 / R5: sweep condition, match number and threshold with mixed data
        for (int cond = 0; cond < 2; cond++) begin
            for (int match = 0; match < 4; match++) begin
                for (int ti = 0; ti < 4; ti++) begin
                    int thr = (ti == 0) ? 0 : (ti == 1) ? 1 : (ti == 2) ? 2048 : 4095;
                    set_cfg(mk_cfg(0, 1, cond[0], 0, match, thr));
                    step(0, 0, 0, 0, 1, "R7");
                    set_cfg(mk_cfg(1, 1, cond[0], 0, match, thr));
                    for (int k = 0; k < 24; k++) begin
                        int d;
                        if (k % 3 == 0) d = thr;
                        else if (k % 3 == 1) d = (thr == 0) ? 0 : thr - 1;
                        else d = (k * 731 + thr * 3 + match * 17) % 4096;
                        step(1, 0, 0, d, (k % 11) == 10, "R4");
                    end
                end
            end
        end

        // R5: run broken by a miss (M=2, at-or-above 100)
        set_cfg(mk_cfg(0, 1, 1, 0, 2, 100));
        step(0, 0, 0, 0, 1, "R5");
        set_cfg(mk_cfg(1, 1, 1, 0, 2, 100));
        step(1, 0, 0, 200, 0, "R5");
        step(1, 0, 0, 150, 0, "R5");
        step(1, 0, 0, 50, 0, "R5");
        step(1, 0, 0, 120, 0, "R5");
        step(1, 0, 0, 100, 0, "R5");
        step(1, 0, 0, 101, 0, "R5");

        // R2: status bit around a threshold, condition below
        set_cfg(mk_cfg(1, 0, 0, 1, 15, 1000));
        for (int d = 990; d <= 1010; d++) step(1, 0, 1, d, 0, "R2");

        // R3: boundary for both conditions, M=0
        for (int cond = 0; cond < 2; cond++) begin
            set_cfg(mk_cfg(1, 1, cond[0], 2, 0, 777));
            for (int d = 775; d <= 779; d++) begin
                step(1, 0, 2, d, 0, "R3");
                step(0, 0, 0, 0, 1, "R3");
            end
        end

        // R6: every select code against every group and index
        for (int sel = 0; sel < 8; sel++) begin
            set_cfg(mk_cfg(1, 1, 1, sel, 0, 2048));
            for (int g = 0; g < 2; g++) begin
                for (int ix = 0; ix < 8; ix++) begin
                    step(1, g[0], ix, (ix + g) % 2 == 0 ? 3000 : 100, 0, "R6");
                    step(0, 0, 0, 0, 1, "R6");
                end
            end
        end

        // R7: disabled, writes to the selected slot change nothing
        set_cfg(mk_cfg(1, 1, 1, 0, 0, 500));
        step(1, 0, 0, 100, 0, "R7");
        set_cfg(mk_cfg(0, 1, 1, 0, 0, 500));
        for (int k = 0; k < 6; k++) step(1, 0, 0, 600 + k, 0, "R7");
        set_cfg(mk_cfg(1, 1, 1, 0, 1, 500));
        step(1, 0, 0, 900, 0, "R7");
        set_cfg(mk_cfg(0, 1, 1, 0, 1, 500));
        step(0, 0, 0, 0, 0, "R7");
        set_cfg(mk_cfg(1, 1, 1, 0, 1, 500));
        step(1, 0, 0, 900, 0, "R7");
        step(1, 0, 0, 900, 0, "R7");

        // R8: sticky, clear, and set colliding with clear
        set_cfg(mk_cfg(1, 1, 0, 4, 0, 300));
        step(0, 0, 0, 0, 1, "R8");
        step(1, 1, 0, 10, 0, "R8");
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 1, "R8");
        step(1, 1, 0, 20, 1, "R8");
        step(0, 0, 0, 0, 0, "R8");

        // R9: interrupt mask while the flag is set
        set_cfg(mk_cfg(1, 0, 0, 4, 0, 300));
        step(0, 0, 0, 0, 0, "R9");
        set_cfg(mk_cfg(1, 1, 0, 4, 0, 300));
        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, "R9");

        // R10: counter restarts after the flag sets (M=1)
        set_cfg(mk_cfg(1, 1, 1, 7, 1, 50));
        step(1, 1, 3, 60, 0, "R10");
        step(1, 1, 3, 70, 0, "R10");
        step(0, 0, 0, 0, 1, "R10");
        step(1, 1, 3, 80, 0, "R10");
        step(1, 1, 3, 90, 0, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule